// File: doc/BRIEF.md
# Linked-List Hardware Queue Manager

This block keeps a set of hardware queues of descriptor addresses, all sharing one link memory. Every descriptor slot has exactly one link entry, so any descriptor can sit in any queue. Each queue has a small header: first index, last index, entry count and byte total. Software or a DMA engine pushes a descriptor by writing its address to a queue's data register, and pops one by reading that same register.

The block turns the address into a link index through a table of descriptor regions, and turns the index back into an address on the way out. It gives an empty or non-empty flag for each queue and a one-cycle error pulse when a pushed address falls in no region. A queue can take each new descriptor at its front, which gives stack order, or at its back, which gives FIFO order. Pops always remove the front entry.

Top module: `lq_manager`

## Requirements
- R1: With back insertion selected, a queue returns pushed addresses in push order. A descriptor that has been popped from one queue can be pushed to another queue and popped from it.
- R2: With front insertion selected (bit 31 of a control write is 1), a queue returns pushed addresses in reverse push order.
- R3: A pushed address that lies inside region r maps to index start_r + ((addr - base_r) >> size_lg_r). A pop returns base_r + ((index - start_r) << size_lg_r), so an address that points inside a slot comes back as that slot's base. Every popped address is 16-byte aligned.
- R4: A push whose address is in no region is dropped. push_err is 1 for exactly the one cycle after that write. No count, byte total or flag changes.
- R5: A pop (read of register 3) from an empty queue returns zero and changes no state.
- R6: Reading register 0 returns the queue's entry count. The count is zero after reset, rises by one on each accepted push and falls by one on each pop.
- R7: Reading register 1 returns the byte total. A push adds the length held in bits 15:0 of the queue's last control write (register 2), and a pop subtracts the length stored with the descriptor it removes.
- R8: Reading register 2 returns the front descriptor's slot size in bytes in bits 31:16 and its packet length in bits 15:0, or zero when the queue is empty.
- R9: A push and a pop to the same queue in the same cycle act as the push followed by the pop.
- R10: q_nonempty[q] is 1 exactly when queue q holds at least one entry, and all flags are 0 after reset.
- R11: Read data appears on rd_data, with rd_valid set, one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_queue | input | $clog2(NUM_Q) | Queue addressed by the write |
| wr_reg | input | 2 | Register: 0 count, 1 bytes, 2 control, 3 data (push) |
| wr_data | input | 32 | Write data: push address, or control {bit31 front insert, bits15:0 length} |
| rd_en | input | 1 | Register read strobe |
| rd_queue | input | $clog2(NUM_Q) | Queue addressed by the read |
| rd_reg | input | 2 | Register: 0 count, 1 bytes, 2 front info, 3 data (pop) |
| rd_data | output | 32 | Read result, registered |
| rd_valid | output | 1 | rd_data holds a result this cycle |
| rgn_base | input | NUM_RGN*32 | Base address of each region |
| rgn_start | input | NUM_RGN*IDX_W | First link index of each region |
| rgn_size_lg | input | NUM_RGN*4 | log2 of slot size in bytes (at least 4) |
| rgn_cnt_lg | input | NUM_RGN*4 | log2 of slot count (at least 5) |
| q_nonempty | output | NUM_Q | Per-queue non-empty flag |
| push_err | output | 1 | Pulse: last push address matched no region |

## Verification
Pushes, control writes and pops all take effect at the clock edge that samples them. A read result appears one edge after rd_en, and the error pulse and the flags are due one edge after the write. The bench drives every strobe for a single cycle starting at a falling edge. It samples results at the next falling edge, which lies half a period after the register that holds them has been loaded. For a read that follows a push or pop, the bench issues it only after that edge, so the read sees the updated header. For the same-cycle case, the push and the pop are applied in one cycle, and the popped address is checked at the following falling edge.

// File: rtl/lq_pkg.sv
// Shared encodings for the linked-list queue manager.
// Assumes a 2-bit register selector per queue.
package lq_pkg;
    typedef enum logic [1:0] {
        LQ_REG_COUNT = 2'd0,
        LQ_REG_BYTES = 2'd1,
        LQ_REG_CTRL  = 2'd2,
        LQ_REG_DATA  = 2'd3
    } lq_reg_e;

    localparam int LQ_CTL_FRONT_BIT = 31;
endpackage

// File: rtl/lq_addr_map.sv
// Address-to-index lookup: finds the region that holds a descriptor
// address and returns its link index using a shift, not a divider.
// Assumes regions do not overlap; the lowest-numbered match wins.
module lq_addr_map #(
    parameter int NUM_RGN = 2,
    parameter int IDX_W   = 6
) (
    input  logic [31:0]                    addr,
    input  logic [NUM_RGN-1:0][31:0]       base,
    input  logic [NUM_RGN-1:0][IDX_W-1:0]  start,
    input  logic [NUM_RGN-1:0][3:0]        size_lg,
    input  logic [NUM_RGN-1:0][3:0]        cnt_lg,
    output logic                           hit,
    output logic [IDX_W-1:0]               idx
);
    logic [31:0] off;
    logic [31:0] slot;

    // Scan regions from highest to lowest so the lowest match is kept.
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        off  = '0;
        slot = '0;
        for (int r = NUM_RGN - 1; r >= 0; r--) begin
            off  = addr - base[r];
            slot = off >> size_lg[r];
            if (addr >= base[r] && slot < (32'd1 << cnt_lg[r])) begin
                hit = 1'b1;
                idx = start[r] + slot[IDX_W-1:0];
            end
        end
    end
endmodule

// File: rtl/lq_index_map.sv
// Index-to-address lookup: finds the region that owns a link index and
// rebuilds the slot address and slot size in bytes.
// Assumes index ranges of regions do not overlap.
module lq_index_map #(
    parameter int NUM_RGN = 2,
    parameter int IDX_W   = 6
) (
    input  logic [IDX_W-1:0]               idx,
    input  logic [NUM_RGN-1:0][31:0]       base,
    input  logic [NUM_RGN-1:0][IDX_W-1:0]  start,
    input  logic [NUM_RGN-1:0][3:0]        size_lg,
    input  logic [NUM_RGN-1:0][3:0]        cnt_lg,
    output logic [31:0]                    addr,
    output logic [15:0]                    size_bytes
);
    logic [IDX_W-1:0] rel;

    // Scan regions from highest to lowest so the lowest match is kept.
    always_comb begin
        addr       = '0;
        size_bytes = '0;
        rel        = '0;
        for (int r = NUM_RGN - 1; r >= 0; r--) begin
            rel = idx - start[r];
            if (idx >= start[r] && 32'(rel) < (32'd1 << cnt_lg[r])) begin
                addr       = base[r] + (32'(rel) << size_lg[r]);
                size_bytes = 16'(32'd1 << size_lg[r]);
            end
        end
    end
endmodule

// File: rtl/lq_manager.sv
// Linked-list queue manager: many queues share one link memory holding a
// next-index entry per descriptor. Each queue keeps front/back index,
// entry count and byte total. Register 3 pushes on write and pops on
// read; register 2 write sets insertion end and push length.
// Assumes each descriptor is in at most one queue at a time, and
// LEN_W <= 16.
module lq_manager
    import lq_pkg::*;
#(
    parameter int NUM_Q   = 8,
    parameter int IDX_W   = 6,
    parameter int NUM_RGN = 2,
    parameter int LEN_W   = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [$clog2(NUM_Q)-1:0]       wr_queue,
    input  logic [1:0]                     wr_reg,
    input  logic [31:0]                    wr_data,
    input  logic                           rd_en,
    input  logic [$clog2(NUM_Q)-1:0]       rd_queue,
    input  logic [1:0]                     rd_reg,
    output logic [31:0]                    rd_data,
    output logic                           rd_valid,
    input  logic [NUM_RGN-1:0][31:0]       rgn_base,
    input  logic [NUM_RGN-1:0][IDX_W-1:0]  rgn_start,
    input  logic [NUM_RGN-1:0][3:0]        rgn_size_lg,
    input  logic [NUM_RGN-1:0][3:0]        rgn_cnt_lg,
    output logic [NUM_Q-1:0]               q_nonempty,
    output logic                           push_err
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int CNT_W = IDX_W + 1;
    localparam int LNK_W = IDX_W + 1;
    localparam logic [LNK_W-1:0] LNK_NULL = {1'b1, {IDX_W{1'b0}}};

    logic [LNK_W-1:0] link_q [DEPTH];
    logic [LEN_W-1:0] plen_q [DEPTH];
    logic [IDX_W-1:0] head_q [NUM_Q];
    logic [IDX_W-1:0] tail_q [NUM_Q];
    logic [CNT_W-1:0] cnt_q  [NUM_Q];
    logic [31:0]      bytes_q[NUM_Q];
    logic             ctl_front_q[NUM_Q];
    logic [LEN_W-1:0] ctl_len_q  [NUM_Q];

    logic             push_go, push_ok, ctl_we, map_hit, wb_en;
    logic [IDX_W-1:0] new_idx, hd1, tl1;
    logic [CNT_W-1:0] cn1;
    logic [31:0]      by1;
    logic [LNK_W-1:0] new_link;
    logic             pop_go, pop_ok, same_q;
    logic [IDX_W-1:0] s_hd, s_tl, rmap_idx;
    logic [CNT_W-1:0] s_cn;
    logic [31:0]      s_by, rmap_addr;
    logic [15:0]      rmap_size;
    logic [LNK_W-1:0] s_next;
    logic [LEN_W-1:0] s_len;

    assign push_go = wr_en && (wr_reg == LQ_REG_DATA);
    assign ctl_we  = wr_en && (wr_reg == LQ_REG_CTRL);
    assign push_ok = push_go && map_hit;
    assign pop_go  = rd_en && (rd_reg == LQ_REG_DATA);

    lq_addr_map #(.NUM_RGN(NUM_RGN), .IDX_W(IDX_W)) fwd_map_i (
        .addr(wr_data), .base(rgn_base), .start(rgn_start),
        .size_lg(rgn_size_lg), .cnt_lg(rgn_cnt_lg),
        .hit(map_hit), .idx(new_idx)
    );

    // Post-push header of the written queue and the link entries it needs.
    always_comb begin
        hd1      = head_q[wr_queue];
        tl1      = tail_q[wr_queue];
        new_link = LNK_NULL;
        wb_en    = 1'b0;
        if (cnt_q[wr_queue] == '0) begin
            hd1 = new_idx;
            tl1 = new_idx;
        end else if (ctl_front_q[wr_queue]) begin
            hd1      = new_idx;
            new_link = {1'b0, head_q[wr_queue]};
        end else begin
            tl1   = new_idx;
            wb_en = 1'b1;
        end
        cn1 = cnt_q[wr_queue] + 1'b1;
        by1 = bytes_q[wr_queue] + 32'(ctl_len_q[wr_queue]);
    end

    // Pop source: the post-push header when both hit the same queue.
    always_comb begin
        same_q = push_ok && (wr_queue == rd_queue);
        s_hd   = same_q ? hd1 : head_q[rd_queue];
        s_tl   = same_q ? tl1 : tail_q[rd_queue];
        s_cn   = same_q ? cn1 : cnt_q[rd_queue];
        s_by   = same_q ? by1 : bytes_q[rd_queue];
        pop_ok = pop_go && (s_cn != '0);
        if (push_ok && s_hd == new_idx) begin
            s_next = new_link;
            s_len  = ctl_len_q[wr_queue];
        end else if (push_ok && wb_en && s_hd == tail_q[wr_queue]) begin
            s_next = {1'b0, new_idx};
            s_len  = plen_q[s_hd];
        end else begin
            s_next = link_q[s_hd];
            s_len  = plen_q[s_hd];
        end
        rmap_idx = (rd_reg == LQ_REG_DATA) ? s_hd : head_q[rd_queue];
    end

    lq_index_map #(.NUM_RGN(NUM_RGN), .IDX_W(IDX_W)) rev_map_i (
        .idx(rmap_idx), .base(rgn_base), .start(rgn_start),
        .size_lg(rgn_size_lg), .cnt_lg(rgn_cnt_lg),
        .addr(rmap_addr), .size_bytes(rmap_size)
    );

    // Thread the pushed descriptor into the shared link memory.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            link_q[new_idx] <= new_link;
            plen_q[new_idx] <= ctl_len_q[wr_queue];
            if (wb_en) link_q[tail_q[wr_queue]] <= {1'b0, new_idx};
        end
    end

    // Header, control and error updates; a pop lands after a push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < NUM_Q; q++) begin
                head_q[q]      <= '0;
                tail_q[q]      <= '0;
                cnt_q[q]       <= '0;
                bytes_q[q]     <= '0;
                ctl_front_q[q] <= 1'b0;
                ctl_len_q[q]   <= '0;
            end
            push_err <= 1'b0;
        end else begin
            if (ctl_we) begin
                ctl_front_q[wr_queue] <= wr_data[LQ_CTL_FRONT_BIT];
                ctl_len_q[wr_queue]   <= wr_data[LEN_W-1:0];
            end
            if (push_ok) begin
                head_q[wr_queue]  <= hd1;
                tail_q[wr_queue]  <= tl1;
                cnt_q[wr_queue]   <= cn1;
                bytes_q[wr_queue] <= by1;
            end
            if (pop_ok) begin
                head_q[rd_queue]  <= s_next[IDX_W-1:0];
                tail_q[rd_queue]  <= s_tl;
                cnt_q[rd_queue]   <= s_cn - 1'b1;
                bytes_q[rd_queue] <= s_by - 32'(s_len);
            end
            push_err <= push_go && !map_hit;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                case (rd_reg)
                    LQ_REG_COUNT: rd_data <= 32'(cnt_q[rd_queue]);
                    LQ_REG_BYTES: rd_data <= bytes_q[rd_queue];
                    LQ_REG_CTRL:  rd_data <= (cnt_q[rd_queue] != '0) ?
                                     {rmap_size, 16'(plen_q[head_q[rd_queue]])} : '0;
                    default:      rd_data <= pop_ok ? rmap_addr : '0;
                endcase
            end
        end
    end

    // Per-queue non-empty flags.
    for (genvar g = 0; g < NUM_Q; g++) begin : g_flag
        assign q_nonempty[g] = (cnt_q[g] != '0);
    end
endmodule

// File: rtl/lq_manager_chk.sv
// Port-level checker for lq_manager, attached by bind below.
module lq_manager_chk #(
    parameter int NUM_Q = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [$clog2(NUM_Q)-1:0] wr_queue,
    input logic [1:0]               wr_reg,
    input logic                     rd_en,
    input logic [$clog2(NUM_Q)-1:0] rd_queue,
    input logic [1:0]               rd_reg,
    input logic [31:0]              rd_data,
    input logic                     rd_valid,
    input logic [NUM_Q-1:0]         q_nonempty,
    input logic                     push_err
);
    // R11
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    // R11
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    // R4
    push_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_err |-> $past(wr_en && wr_reg == 2'd3));
    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_reg == 2'd3 && !q_nonempty[rd_queue] &&
         !(wr_en && wr_reg == 2'd3 && wr_queue == rd_queue)) |=> (rd_data == 32'd0));
    // R8
    empty_info_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_reg == 2'd2 && !q_nonempty[rd_queue]) |=> (rd_data == 32'd0));
    // R10
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(q_nonempty) > $past($countones(q_nonempty))) |-> $past(wr_en && wr_reg == 2'd3));
    // R10
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(q_nonempty) < $past($countones(q_nonempty))) |-> $past(rd_en && rd_reg == 2'd3));
    // R3
    pop_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_reg == 2'd3) |=> (rd_data[3:0] == 4'd0));
endmodule

bind lq_manager lq_manager_chk #(.NUM_Q(NUM_Q)) chk_i (.*);

// File: tb/lq_manager_tb_top.sv
module lq_manager_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  wr_queue = '0, rd_queue = '0;
    logic [1:0]  wr_reg = '0, rd_reg = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rd_valid, push_err;
    logic [7:0]  q_nonempty;
    logic [1:0][31:0] rgn_base;
    logic [1:0][5:0]  rgn_start;
    logic [1:0][3:0]  rgn_size_lg, rgn_cnt_lg;
    int checks = 0;
    int failures = 0;

    // Region 0: 32 slots of 32 bytes; region 1: 32 slots of 64 bytes.
    assign rgn_base    = {32'h2000_0000, 32'h1000_0000};
    assign rgn_start   = {6'd32, 6'd0};
    assign rgn_size_lg = {4'd6, 4'd5};
    assign rgn_cnt_lg  = {4'd5, 4'd5};

    always #2 clk = ~clk;

    lq_manager dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_queue(wr_queue), .wr_reg(wr_reg), .wr_data(wr_data),
        .rd_en(rd_en), .rd_queue(rd_queue), .rd_reg(rd_reg),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .rgn_base(rgn_base), .rgn_start(rgn_start),
        .rgn_size_lg(rgn_size_lg), .rgn_cnt_lg(rgn_cnt_lg),
        .q_nonempty(q_nonempty), .push_err(push_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int q, input int r, input logic [31:0] d);
        wr_en = 1'b1; wr_queue = 3'(q); wr_reg = 2'(r); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int q, input int r, output logic [31:0] d);
        rd_en = 1'b1; rd_queue = 3'(q); rd_reg = 2'(r);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R10 flags after reset", 32'(q_nonempty), 32'd0);
        rd(0, 0, v); check("R6 count after reset", v, 32'd0);
        check("R11 valid after read", 32'(rd_valid), 32'd1);
        @(negedge clk);
        check("R11 valid idle", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_fifo();
        logic [31:0] v;
        wr(1, 2, 32'd100); wr(1, 3, 32'h1000_0000);
        wr(1, 2, 32'd200); wr(1, 3, 32'h1000_0020);
        wr(1, 2, 32'd50);  wr(1, 3, 32'h2000_0040);
        check("R10 q1 flag set", 32'(q_nonempty[1]), 32'd1);
        rd(1, 0, v); check("R6 q1 count", v, 32'd3);
        rd(1, 1, v); check("R7 q1 bytes", v, 32'd350);
        rd(1, 2, v); check("R8 q1 front info", v, {16'd32, 16'd100});
        rd(1, 3, v); check("R1 first pop", v, 32'h1000_0000);
        rd(1, 1, v); check("R7 bytes after pop", v, 32'd250);
        rd(1, 2, v); check("R8 front info 2", v, {16'd32, 16'd200});
        rd(1, 3, v); check("R1 second pop", v, 32'h1000_0020);
        rd(1, 2, v); check("R8 region1 size", v, {16'd64, 16'd50});
        rd(1, 3, v); check("R3 region1 round trip", v, 32'h2000_0040);
        check("R10 q1 flag clear", 32'(q_nonempty[1]), 32'd0);
        rd(1, 1, v); check("R7 bytes back to zero", v, 32'd0);
        rd(1, 2, v); check("R8 empty info", v, 32'd0);
        wr(6, 3, 32'h1000_0000);
        rd(6, 3, v); check("R1 reuse in other queue", v, 32'h1000_0000);
    endtask

    task automatic t_lifo();
        logic [31:0] v;
        wr(2, 2, 32'h8000_0010);
        wr(2, 3, 32'h1000_0040); wr(2, 3, 32'h1000_0060); wr(2, 3, 32'h2000_0080);
        rd(2, 1, v); check("R7 front-insert bytes", v, 32'd48);
        rd(2, 3, v); check("R2 pop newest", v, 32'h2000_0080);
        rd(2, 3, v); check("R2 pop middle", v, 32'h1000_0060);
        rd(2, 3, v); check("R2 pop oldest", v, 32'h1000_0040);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(3, 3, 32'h2000_0048);
        rd(3, 3, v); check("R3 inside-slot address", v, 32'h2000_0040);
        wr(3, 3, 32'h3000_0000);
        check("R4 err pulse high", 32'(push_err), 32'd1);
        @(negedge clk);
        check("R4 err pulse one cycle", 32'(push_err), 32'd0);
        wr(3, 3, 32'h0FFF_FFF0);
        check("R4 below region0", 32'(push_err), 32'd1);
        wr(3, 3, 32'h1000_0400);
        check("R4 past region0 end", 32'(push_err), 32'd1);
        rd(3, 0, v); check("R4 count unchanged", v, 32'd0);
        check("R4 flags unchanged", 32'(q_nonempty), 32'd0);
    endtask

    task automatic t_empty();
        logic [31:0] v;
        rd(4, 3, v); check("R5 empty pop zero", v, 32'd0);
        rd(4, 0, v); check("R5 count stays zero", v, 32'd0);
        rd(4, 1, v); check("R5 bytes stay zero", v, 32'd0);
    endtask

    task automatic t_same();
        logic [31:0] v;
        wr(5, 2, 32'd7);
        wr_en = 1'b1; wr_queue = 3'd5; wr_reg = 2'd3; wr_data = 32'h1000_0100;
        rd_en = 1'b1; rd_queue = 3'd5; rd_reg = 2'd3;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R9 empty push+pop", rd_data, 32'h1000_0100);
        check("R9 flag stays clear", 32'(q_nonempty[5]), 32'd0);
        wr(5, 3, 32'h1000_0120);
        wr_en = 1'b1; wr_data = 32'h1000_0140; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R9 pop older first", rd_data, 32'h1000_0120);
        rd(5, 0, v); check("R9 count one", v, 32'd1);
        rd(5, 1, v); check("R9 bytes one", v, 32'd7);
        rd(5, 3, v); check("R9 pushed entry kept", v, 32'h1000_0140);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fifo();
        t_lifo();
        t_map();
        t_empty();
        t_same();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule